// File: doc/BRIEF.md
# SDRAM Clock-Enable Mode Controller

This block sits on the controller side of a two-bank synchronous DRAM interface and owns the clock-enable pin. Upstream logic asks it to enter a low-activity mode with a one-cycle request strobe. Later it leaves that mode with a one-cycle release strobe.

The block does not take the target mode from the request. It decides the mode in the first cycle that the pin is low. If every bank has finished its access operation, the memory goes to power-down. If any bank is still in a read or write access, the memory goes to clock suspend.

A bank's access operation runs through three phases:
- It starts with a read or write command to that bank.
- It lasts through that bank's data cycles.
- After the last read data-out cycle it ends one cycle later. After the last write data-in cycle it ends two cycles later.

A request is never granted in a cycle that carries write data. Such a request is not dropped: it stays pending until the first cycle without write data.

On leaving power-down, the timing of the next command depends on a configuration input that states whether the setup time from clock-enable high to the clock is guaranteed. If it is not guaranteed, the block holds back the command-permission output for the first cycle with the pin high. This forces one no-operation cycle.

There is no data stream through this block. The command-permission output acts as the only back-pressure. Upstream may issue a command other than no-operation only in a cycle where permission is high. A command issued while permission is low is treated by the memory as a no-operation and should not be issued. The block ignores the address, data-mask and chip-select path entirely.

Top module: `cke_mode_ctrl`

## Requirements
- R1: After reset, the clock-enable output is 1, the mode output is 2'b00 (idle) and the command permission is 1.
- R2: Mode encoding is 00 idle, 01 active, 10 power-down, 11 clock suspend. While the clock-enable output is high and no low mode is in force, the mode shows 01 in the cycle after a cycle in which any bank was in an access operation, and 00 otherwise.
- R3: A granted request drives the clock-enable output low in the next cycle. Command permission stays 1 in that first low cycle. If no bank is in access in that first low cycle, the mode becomes 10 in the following cycle.
- R4: If any bank is in access in the first low cycle, the mode becomes 11 in the following cycle instead.
- R5: A bank is in access in a cycle with read data-out for it, and is no longer in access in the next cycle unless more data or a command arrives.
- R6: A bank is in access in a cycle with write data-in for it and in the cycle after, and is no longer in access two cycles after the last such cycle.
- R7: A request is not granted in any cycle where any bank has write data-in. It is held pending and granted in the first cycle without write data, in the normal running state.
- R8: A release while in power-down or suspend drives the clock-enable output high in the next cycle. One cycle later the mode returns to 00 or 01.
- R9: In the first high cycle after a power-down exit, command permission is 0 when the setup-guaranteed input is 0 and 1 when it is 1. After a suspend exit, permission is 1 regardless of that input.
- R10: Command permission is 0 in every cycle in which the clock-enable output is low and was also low in the previous cycle.
- R11: A request while in power-down or suspend is ignored. A release in the running state clears any pending request and otherwise has no effect. A release together with a request in the running state grants nothing.
- R12: A read (cmd_op 3'b001) or write (cmd_op 3'b010) command to a bank puts that bank in access from the command cycle until its data tail ends. Between the command and the bank's first data cycle, the bank is in access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command issued this cycle (000 no-op, 001 read, 010 write, others neutral) |
| cmd_bank | input | 1 | Bank addressed by the command |
| rd_dv | input | 2 | Per-bank read data-out cycle marker |
| wr_dv | input | 2 | Per-bank write data-in cycle marker |
| lp_req | input | 1 | Strobe: request entry to a low-activity mode |
| lp_rel | input | 1 | Strobe: release the low-activity mode |
| exit_setup_ok | input | 1 | 1 when the clock-enable-high setup to the clock is guaranteed |
| cke | output | 1 | Clock-enable pin drive |
| mode | output | 2 | Mode status (see R2) |
| cmd_allow | output | 1 | Upstream may issue a non-no-op command this cycle |

## Verification
Several of the block's decisions can fall in the same cycle. The bench provokes each of these collisions deliberately.

The main one is an entry request that lands on a write data-in cycle. The bench raises the request on the first of several write data cycles. It expects the clock-enable output to stay high until the cycle after the last data. From the write tail it then expects power-down, not suspend.

The second collision is a request and a release in the same running cycle. The third is a release that clears a request held pending by write data. In both cases the bench expects the pin never to fall.

A cycle-accurate behavioural model in the bench judges every one of these cycles.

// File: rtl/cke_pkg.sv
package cke_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_ACT  = 2'b01,
    MODE_PD   = 2'b10,
    MODE_SUSP = 2'b11
  } cke_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ENTER,
    ST_LOW,
    ST_WAKE
  } cke_st_e;

  localparam logic [2:0] OP_NOP   = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;

endpackage

// File: rtl/cke_bank_track.sv
module cke_bank_track #(
  parameter int RD_TAIL = 1,
  parameter int WR_TAIL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_hit,
  input  logic rd_dv,
  input  logic wr_dv,
  output logic busy
);

  localparam int MAX_TAIL = (WR_TAIL > RD_TAIL) ? WR_TAIL : RD_TAIL;
  localparam int CNT_W    = (MAX_TAIL > 1) ? $clog2(MAX_TAIL) : 1;
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_TAIL - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_TAIL - 1);

  logic             await_q;
  logic [CNT_W-1:0] tail_q;
  logic [CNT_W-1:0] tail_dec;
  logic [CNT_W-1:0] load_rd;
  logic [CNT_W-1:0] load_wr;
  logic [CNT_W-1:0] tail_nxt;

  always_comb begin
    tail_dec = (tail_q != '0) ? tail_q - 1'b1 : '0;
    load_rd  = rd_dv ? RD_LOAD : '0;
    load_wr  = wr_dv ? WR_LOAD : '0;
    tail_nxt = tail_dec;
    if (load_rd > tail_nxt) tail_nxt = load_rd;
    if (load_wr > tail_nxt) tail_nxt = load_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      await_q <= 1'b0;
      tail_q  <= '0;
    end else begin
      tail_q <= tail_nxt;
      if (cmd_hit)             await_q <= 1'b1;
      else if (rd_dv || wr_dv) await_q <= 1'b0;
    end
  end

  assign busy = cmd_hit | await_q | rd_dv | wr_dv | (tail_q != '0);

  // R6
  wr_tail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dv |=> busy);

  // R12
  cmd_await_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> busy);

endmodule

// File: rtl/cke_entry_gate.sv
module cke_entry_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic lp_rel,
  input  logic in_run,
  input  logic in_low,
  input  logic wr_any,
  output logic grant
);

  logic pend_q;

  assign grant = in_run & ~lp_rel & ~wr_any & (pend_q | lp_req);

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (grant || lp_rel)   pend_q <= 1'b0;
    else if (lp_req && !in_low) pend_q <= 1'b1;
  end

  // R7
  no_grant_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> !grant);

endmodule

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       lp_rel,
  input  logic       busy_any,
  input  logic       exit_setup_ok,
  output logic       in_run,
  output logic       in_low,
  output logic       cke,
  output logic [1:0] mode,
  output logic       cmd_allow
);

  cke_st_e   st_q;
  cke_mode_e mode_q;
  logic      cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      mode_q <= MODE_IDLE;
      cke_q  <= 1'b1;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          mode_q <= busy_any ? MODE_ACT : MODE_IDLE;
          if (grant) begin
            st_q  <= ST_ENTER;
            cke_q <= 1'b0;
          end
        end
        ST_ENTER: begin
          mode_q <= busy_any ? MODE_SUSP : MODE_PD;
          st_q   <= ST_LOW;
        end
        ST_LOW: begin
          if (lp_rel) begin
            st_q  <= ST_WAKE;
            cke_q <= 1'b1;
          end
        end
        default: begin
          mode_q <= busy_any ? MODE_ACT : MODE_IDLE;
          st_q   <= ST_RUN;
        end
      endcase
    end
  end

  assign in_run    = (st_q == ST_RUN);
  assign in_low    = (st_q == ST_LOW);
  assign cke       = cke_q;
  assign mode      = mode_q;
  assign cmd_allow = (st_q == ST_RUN) || (st_q == ST_ENTER) ||
                     ((st_q == ST_WAKE) && (exit_setup_ok || mode_q == MODE_SUSP));

  // R10
  hold_low_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> !cmd_allow);

  // R9
  pd_exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && mode == MODE_PD && !exit_setup_ok) |-> !cmd_allow);

  // R8
  wake_mode_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> (mode == MODE_IDLE || mode == MODE_ACT));

  // R3
  enter_keeps_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> cmd_allow);

endmodule

// File: rtl/cke_mode_ctrl.sv
module cke_mode_ctrl
  import cke_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int RD_TAIL = 1,
  parameter int WR_TAIL = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [NBANK-1:0]  rd_dv,
  input  logic [NBANK-1:0]  wr_dv,
  input  logic              lp_req,
  input  logic              lp_rel,
  input  logic              exit_setup_ok,
  output logic              cke,
  output logic [1:0]        mode,
  output logic              cmd_allow
);

  logic [NBANK-1:0] busy_vec;
  logic             is_access;
  logic             busy_any;
  logic             wr_any;
  logic             grant;
  logic             in_run;
  logic             in_low;

  assign is_access = (cmd_op == OP_READ) || (cmd_op == OP_WRITE);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cke_bank_track #(
      .RD_TAIL(RD_TAIL),
      .WR_TAIL(WR_TAIL)
    ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_hit(is_access && (cmd_bank == BANK_W'(b))),
      .rd_dv  (rd_dv[b]),
      .wr_dv  (wr_dv[b]),
      .busy   (busy_vec[b])
    );
  end

  assign busy_any = |busy_vec;
  assign wr_any   = |wr_dv;

  cke_entry_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .lp_req(lp_req),
    .lp_rel(lp_rel),
    .in_run(in_run),
    .in_low(in_low),
    .wr_any(wr_any),
    .grant (grant)
  );

  cke_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (grant),
    .lp_rel       (lp_rel),
    .busy_any     (busy_any),
    .exit_setup_ok(exit_setup_ok),
    .in_run       (in_run),
    .in_low       (in_low),
    .cke          (cke),
    .mode         (mode),
    .cmd_allow    (cmd_allow)
  );

  // R7
  fall_no_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(wr_any));

  // R4
  susp_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cke) && $past(cke, 2) && mode == 2'b11) |-> $past(busy_any));

endmodule

// File: tb/cke_mode_ctrl_tb_top.sv
module cke_mode_ctrl_tb_top;

  localparam int CLK_P   = 10;
  localparam int WR_TAIL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd_op = 3'b000;
  logic [0:0] cmd_bank = 1'b0;
  logic [1:0] rd_dv = 2'b00;
  logic [1:0] wr_dv = 2'b00;
  logic       lp_req = 1'b0;
  logic       lp_rel = 1'b0;
  logic       exit_setup_ok = 1'b1;
  logic       cke;
  logic [1:0] mode;
  logic       cmd_allow;

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference state
  int m_st = 0;            // 0 running, 1 first low, 2 low, 3 first high
  int m_mode = 0;
  int m_cke = 1;
  int m_pend = 0;
  int m_cyc = 0;
  int m_await[2] = '{0, 0};
  int m_lastwr[2] = '{-100, -100};

  always #(CLK_P/2) clk = ~clk;

  cke_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .rd_dv(rd_dv), .wr_dv(wr_dv), .lp_req(lp_req), .lp_rel(lp_rel),
    .exit_setup_ok(exit_setup_ok), .cke(cke), .mode(mode), .cmd_allow(cmd_allow)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, what, act, exp, m_cyc);
    end
  endtask

  task automatic step(input logic [2:0] op, input int bk, input logic [1:0] rd,
                      input logic [1:0] wr, input logic rq, input logic rl, input string tag);
    int exp_allow;
    int busy;
    int grant;
    int hit;
    cmd_op = op; cmd_bank = 1'(bk); rd_dv = rd; wr_dv = wr; lp_req = rq; lp_rel = rl;
    #1;
    exp_allow = (m_st == 0 || m_st == 1 ||
                 (m_st == 3 && (exit_setup_ok || m_mode == 3))) ? 1 : 0;
    chk(tag, "cke", int'(cke), m_cke);
    chk(tag, "mode", int'(mode), m_mode);
    chk(tag, "cmd_allow", int'(cmd_allow), exp_allow);
    busy = 0;
    for (int b = 0; b < 2; b++) begin
      hit = ((op == 3'b001 || op == 3'b010) && bk == b) ? 1 : 0;
      if (hit != 0 || m_await[b] != 0 || rd[b] || wr[b] ||
          (m_cyc - m_lastwr[b] > 0 && m_cyc - m_lastwr[b] < WR_TAIL)) busy = 1;
    end
    grant = (m_st == 0 && !rl && wr == 2'b00 && (m_pend != 0 || rq)) ? 1 : 0;
    if (grant != 0 || rl) m_pend = 0;
    else if (rq && m_st != 2) m_pend = 1;
    case (m_st)
      0: begin
        m_mode = busy ? 1 : 0;
        if (grant != 0) begin m_st = 1; m_cke = 0; end
      end
      1: begin m_mode = busy ? 3 : 2; m_st = 2; end
      2: if (rl) begin m_st = 3; m_cke = 1; end
      default: begin m_mode = busy ? 1 : 0; m_st = 0; end
    endcase
    for (int b = 0; b < 2; b++) begin
      hit = ((op == 3'b001 || op == 3'b010) && bk == b) ? 1 : 0;
      if (wr[b]) m_lastwr[b] = m_cyc;
      if (hit != 0) m_await[b] = 1;
      else if (rd[b] || wr[b]) m_await[b] = 0;
    end
    m_cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(2, "R1");
    // R2 read data marks activity
    step(3'b000, 0, 2'b01, 2'b00, 1'b0, 1'b0, "R2");
    idle(2, "R2");
    // R3 power-down entry, R8 exit with setup guaranteed, R10 held low
    step(3'b000, 0, 2'b00, 2'b00, 1'b1, 1'b0, "R3");
    idle(2, "R3");
    idle(2, "R10");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R8");
    idle(3, "R8");
    // R9 exit without setup guarantee
    exit_setup_ok = 1'b0;
    step(3'b000, 0, 2'b00, 2'b00, 1'b1, 1'b0, "R9");
    idle(3, "R9");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R9");
    idle(3, "R9");
    // R4 suspend during read burst, suspend exit keeps permission
    step(3'b000, 0, 2'b01, 2'b00, 1'b1, 1'b0, "R4");
    step(3'b000, 0, 2'b01, 2'b00, 1'b0, 1'b0, "R4");
    step(3'b000, 0, 2'b01, 2'b00, 1'b0, 1'b0, "R4");
    step(3'b000, 0, 2'b01, 2'b00, 1'b0, 1'b1, "R9");
    step(3'b000, 0, 2'b01, 2'b00, 1'b0, 1'b0, "R9");
    idle(3, "R4");
    // R5 read tail: read on grant cycle gives power-down
    step(3'b000, 1, 2'b10, 2'b00, 1'b1, 1'b0, "R5");
    idle(3, "R5");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R5");
    idle(2, "R5");
    // R7 request on write data held pending; R6 write tail
    exit_setup_ok = 1'b1;
    step(3'b000, 1, 2'b00, 2'b10, 1'b1, 1'b0, "R7");
    step(3'b000, 1, 2'b00, 2'b10, 1'b0, 1'b0, "R7");
    step(3'b000, 1, 2'b00, 2'b10, 1'b0, 1'b0, "R7");
    idle(4, "R6");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R6");
    idle(2, "R6");
    // R6 write tail seen by mode in running state
    step(3'b000, 0, 2'b00, 2'b01, 1'b0, 1'b0, "R6");
    idle(3, "R6");
    // R11 request while low ignored; release in running ignored
    step(3'b000, 0, 2'b00, 2'b00, 1'b1, 1'b0, "R11");
    idle(2, "R11");
    step(3'b000, 0, 2'b00, 2'b00, 1'b1, 1'b0, "R11");
    idle(2, "R11");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R11");
    idle(3, "R11");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R11");
    step(3'b000, 0, 2'b00, 2'b00, 1'b1, 1'b1, "R11");
    idle(2, "R11");
    step(3'b000, 0, 2'b00, 2'b01, 1'b1, 1'b0, "R11");
    step(3'b000, 0, 2'b00, 2'b01, 1'b0, 1'b1, "R11");
    idle(4, "R11");
    // R12 command without data yet keeps the bank in access
    step(3'b001, 1, 2'b00, 2'b00, 1'b1, 1'b0, "R12");
    idle(3, "R12");
    step(3'b000, 0, 2'b00, 2'b00, 1'b0, 1'b1, "R12");
    idle(2, "R12");
    step(3'b000, 1, 2'b10, 2'b00, 1'b0, 1'b0, "R12");
    idle(3, "R12");
    step(3'b010, 0, 2'b00, 2'b00, 1'b0, 1'b0, "R12");
    idle(2, "R12");
    step(3'b000, 0, 2'b00, 2'b01, 1'b0, 1'b0, "R12");
    idle(3, "R12");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule